// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

The block is a register-mapped timer with four independent 16-bit counting channels. Each channel counts edges of a shared count-clock input, after an edge selector and a divide-by-4^p prescaler. It compares its counter against four compare values and can clear the counter on a match with any one of them. One pin per channel is driven from a 3-bit output code. The code gives a starting level and the action taken when compare value A matches. In PWM mode the pin also goes back to its starting level whenever the counter clears.

Software places a channel in PWM mode and selects compare B as the clear source. The pin then holds its starting level from count zero up to the compare-A match and takes the A action until the compare-B match, when the cycle begins again. A single shared run register starts and stops each channel. While a channel is stopped, a write of the output code sets its pin to the starting level, so constant 0% or 100% outputs need no running counter. Every channel also keeps two sticky match flags, one for A and one for B.

Top module: `cmpwm_timer`

## Requirements
- R1: The run register at byte address 0x00 holds one bit per channel, and bit n runs channel n. A stopped channel's counter keeps its value. The run register reads back what was written.
- R2: Channel n's registers start at byte address 0x10 + 0x40*n. They are control +0x00, mode +0x04, output code +0x08, interrupt enable +0x0C, flags +0x10, counter +0x14 and compare A/B/C/D at +0x18/+0x1C/+0x20/+0x24. Each is 16 bits, and read data appears one clock after the address.
- R3: A write to the counter loads it, and that write takes priority over counting in the same cycle.
- R4: Control bits 4:3 pick the counted edge of the count-clock input: 0 counts rising edges, 1 counts falling edges, 2 or 3 counts both.
- R5: Control bits 1:0 give p, and the counter advances once per 4^p selected edges.
- R6: Control bits 7:5 pick the clear source: 1 for A, 2 for B, 5 for C, 6 for D, anything else for none. A count on which the counter equals the selected compare value loads 0, so the cycle lasts (value + 1) counts.
- R7: Output-code bit 2 is the starting level. Bits 1:0 give the action on a compare-A match: 0 holds, 1 drives 0, 2 drives 1, 3 inverts. In mode 0 (normal) the pin changes only on A matches.
- R8: In mode 2 (PWM, mode bits 1:0) the pin returns to its starting level on the count that clears the counter. With B as the clear source, the pin spends (B - A) of every (B + 1) counts in the A-action level.
- R9: A write to the output code of a stopped channel drives its pin to the new bit-2 level on the same clock edge.
- R10: Flag bit 0 is set by a compare-A match and bit 1 by a compare-B match. Writing 0 to a flag bit clears it, and a match in the same cycle as that clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| count_src | input | 1 | Count-clock input, sampled on clk |
| pwm_out | output | 4 | One output pin per channel |

## Verification
Two events can land on the same clock edge. A compare-A match can set a flag while a software write clears that flag. A counter write can also coincide with a count. The bench provokes the first case exactly: it loads the counter with the compare-A value and selects both-edge counting with a toggling count input, which gives a count on every clock. It then writes the run bit and the flag-clear back to back, so the first count lands on the edge that takes the clear. The flag must read back as set. Duty and edge-mode checks count the high cycles and the rising transitions of the pin over windows that are whole multiples of the period, so the results do not depend on the start phase.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;
  localparam int OFFW = 6;
  localparam logic [OFFW-1:0] OFF_CTL  = 6'h00;
  localparam logic [OFFW-1:0] OFF_MODE = 6'h04;
  localparam logic [OFFW-1:0] OFF_IOC  = 6'h08;
  localparam logic [OFFW-1:0] OFF_IER  = 6'h0C;
  localparam logic [OFFW-1:0] OFF_FLAG = 6'h10;
  localparam logic [OFFW-1:0] OFF_CNT  = 6'h14;
  localparam logic [OFFW-1:0] OFF_CMPA = 6'h18;
  localparam logic [OFFW-1:0] OFF_CMPB = 6'h1C;
  localparam logic [OFFW-1:0] OFF_CMPC = 6'h20;
  localparam logic [OFFW-1:0] OFF_CMPD = 6'h24;

  typedef enum logic [2:0] {
    CLR_NONE = 3'd0, CLR_A = 3'd1, CLR_B = 3'd2, CLR_C = 3'd5, CLR_D = 3'd6
  } clr_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_INV = 2'd3
  } match_act_e;

  localparam logic [1:0] MODE_PWM = 2'd2;
endpackage

// File: rtl/cmpwm_tickgen.sv
module cmpwm_tickgen #(
  parameter int PS_STEPS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       src,
  input  logic [1:0] edge_sel,
  input  logic [1:0] psel,
  output logic       tick
);
  localparam int PCW = 2 * (PS_STEPS - 1);

  logic           src_q;
  logic           edge_hit;
  logic [PCW-1:0] pre_q;
  logic [PCW-1:0] mask;

  always_comb begin
    unique case (edge_sel)
      2'd0:    edge_hit = src & ~src_q;
      2'd1:    edge_hit = ~src & src_q;
      default: edge_hit = src ^ src_q;
    endcase
    mask = PCW'((1 << (2 * psel)) - 1);
    tick = en && edge_hit && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      pre_q <= '0;
    end else begin
      src_q <= src;
      if (!en || tick)   pre_q <= '0;
      else if (edge_hit) pre_q <= pre_q + 1'b1;
    end
  end

  a_r5_tick_on_edge: assert property (@(posedge clk) disable iff (rst)
    tick |-> (en && edge_hit));
endmodule

// File: rtl/cmpwm_channel.sv
module cmpwm_channel
  import cmpwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          count_src,
  input  logic          we,
  input  logic [OFFW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pin
);
  logic [DW-1:0] ctl_q, mode_q, ioc_q, ier_q, cnt_q;
  logic [DW-1:0] cmp_q [4];
  logic [1:0]    flag_q;
  logic          pin_q;
  logic          tick, hit_a, hit_b, clr_hit;
  logic [3:0]    hits;
  logic          ioc_wr, cnt_wr, flag_wr;
  logic [1:0]    flag_n;

  cmpwm_tickgen #(.PS_STEPS(4)) u_tick (
    .clk(clk), .rst(rst), .en(run), .src(count_src),
    .edge_sel(ctl_q[4:3]), .psel(ctl_q[1:0]), .tick(tick)
  );

  for (genvar k = 0; k < 4; k++) begin : g_cmp
    assign hits[k] = tick && (cnt_q == cmp_q[k]);
  end
  assign hit_a = hits[0];
  assign hit_b = hits[1];

  always_comb begin
    unique case (ctl_q[7:5])
      CLR_A:   clr_hit = hits[0];
      CLR_B:   clr_hit = hits[1];
      CLR_C:   clr_hit = hits[2];
      CLR_D:   clr_hit = hits[3];
      default: clr_hit = 1'b0;
    endcase
    ioc_wr  = we && (off == OFF_IOC);
    cnt_wr  = we && (off == OFF_CNT);
    flag_wr = we && (off == OFF_FLAG);
    flag_n  = flag_wr ? (flag_q & wdata[1:0]) : flag_q;
    flag_n  = flag_n | {hit_b, hit_a};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0; mode_q <= '0; ioc_q <= '0; ier_q <= '0;
      cnt_q <= '0; flag_q <= '0; pin_q <= 1'b0;
      for (int k = 0; k < 4; k++) cmp_q[k] <= '1;
    end else begin
      flag_q <= flag_n;
      if (we) begin
        unique case (off)
          OFF_CTL:  ctl_q    <= wdata;
          OFF_MODE: mode_q   <= wdata;
          OFF_IOC:  ioc_q    <= wdata;
          OFF_IER:  ier_q    <= wdata;
          OFF_CMPA: cmp_q[0] <= wdata;
          OFF_CMPB: cmp_q[1] <= wdata;
          OFF_CMPC: cmp_q[2] <= wdata;
          OFF_CMPD: cmp_q[3] <= wdata;
          default: ;
        endcase
      end
      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
      if (ioc_wr && !run) begin
        pin_q <= wdata[2];
      end else if ((mode_q[1:0] == MODE_PWM) && clr_hit) begin
        pin_q <= ioc_q[2];
      end else if (hit_a) begin
        unique case (match_act_e'(ioc_q[1:0]))
          ACT_LOW:  pin_q <= 1'b0;
          ACT_HIGH: pin_q <= 1'b1;
          ACT_INV:  pin_q <= ~pin_q;
          default:  pin_q <= pin_q;
        endcase
      end
    end
  end

  always_comb begin
    unique case (off)
      OFF_CTL:  rdata = ctl_q;
      OFF_MODE: rdata = mode_q;
      OFF_IOC:  rdata = ioc_q;
      OFF_IER:  rdata = ier_q;
      OFF_FLAG: rdata = DW'(flag_q);
      OFF_CNT:  rdata = cnt_q;
      OFF_CMPA: rdata = cmp_q[0];
      OFF_CMPB: rdata = cmp_q[1];
      OFF_CMPC: rdata = cmp_q[2];
      OFF_CMPD: rdata = cmp_q[3];
      default:  rdata = '0;
    endcase
  end

  assign pin = pin_q;

  a_r1_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt_q));
  a_r9_fixed_level: assert property (@(posedge clk) disable iff (rst)
    (ioc_wr && !run) |=> (pin_q == $past(wdata[2])));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    hit_a |=> flag_q[0]);
  a_r6_clear_b: assert property (@(posedge clk) disable iff (rst)
    (tick && ctl_q[7:5] == 3'd2 && cnt_q == cmp_q[1] && !cnt_wr) |=> (cnt_q == '0));
endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
  import cmpwm_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int CH_BASE = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_we,
  output logic [DW-1:0]  bus_rdata,
  input  logic           count_src,
  output logic [NCH-1:0] pwm_out
);
  localparam int IDXW = AW - OFFW;

  logic [NCH-1:0]  run_q;
  logic [AW-1:0]   rel;
  logic            in_ch;
  logic [IDXW-1:0] ch_idx;
  logic [DW-1:0]   ch_rd [NCH];
  logic [DW-1:0]   rd_n;

  assign rel    = bus_addr - AW'(CH_BASE);
  assign in_ch  = bus_addr >= AW'(CH_BASE);
  assign ch_idx = rel[AW-1:OFFW];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmpwm_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .run(run_q[g]), .count_src(count_src),
      .we(bus_we && in_ch && (ch_idx == IDXW'(g))),
      .off(rel[OFFW-1:0]), .wdata(bus_wdata),
      .rdata(ch_rd[g]), .pin(pwm_out[g])
    );
  end

  always_comb begin
    rd_n = '0;
    if (bus_addr == '0) rd_n = DW'(run_q);
    else if (in_ch && (int'(ch_idx) < NCH)) rd_n = ch_rd[ch_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_n;
      if (bus_we && bus_addr == '0) run_q <= bus_wdata[NCH-1:0];
    end
  end

  a_r1_run_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == '0) |=> (run_q == $past(bus_wdata[NCH-1:0])));
endmodule

// File: tb/cmpwm_timer_tb.sv
module cmpwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        count_src = 1'b0;
  logic [3:0]  pwm_out;
  int n_chk = 0;
  int n_bad = 0;

  cmpwm_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .count_src(count_src),
    .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) count_src <= ~count_src;

  function automatic logic [7:0] ra(input int ch, input int off);
    return 8'(16 + 64 * ch + off);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic measure(input int ch, input int len, output int highs, output int rises);
    logic prev = pwm_out[ch];
    highs = 0; rises = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  // Channel 0 PWM: init 0, set on A, clear on B, A=3 B=9.
  task automatic run_pwm(input int edge_sel, input int p, input int win,
                         input int exp_hi, input int exp_rise, input string req);
    int hi, rs;
    wr(8'h00, 16'h0);
    wr(ra(0, 'h08), 16'h0000);
    wr(ra(0, 'h00), 16'((2 << 5) | (edge_sel << 3) | p));
    wr(ra(0, 'h04), 16'h0002);
    wr(ra(0, 'h08), 16'h0002);
    wr(ra(0, 'h18), 16'd3);
    wr(ra(0, 'h1C), 16'd9);
    wr(ra(0, 'h14), 16'd0);
    wr(8'h00, 16'h1);
    repeat (100) @(negedge clk);
    measure(0, win, hi, rs);
    check({req, " high cycles"}, hi, exp_hi);
    check({req, " rising transitions"}, rs, exp_rise);
  endtask

  task automatic t_reset;
    int v;
    rd(8'h00, v);          check("R1 reset run register", v, 0);
    check("R9 reset pin level", int'(pwm_out), 0);
    rd(ra(2, 'h14), v);    check("R3 reset counter", v, 0);
  endtask

  task automatic t_regmap;
    int v;
    wr(ra(3, 'h24), 16'hBEEF);
    wr(ra(3, 'h0C), 16'h00A5);
    wr(ra(1, 'h04), 16'h0072);
    rd(ra(3, 'h24), v);    check("R2 ch3 compare D", v, 'hBEEF);
    rd(ra(3, 'h0C), v);    check("R2 ch3 interrupt enable", v, 'h00A5);
    rd(ra(1, 'h04), v);    check("R2 ch1 mode with buffer bits", v, 'h0072);
    rd(ra(2, 'h24), v);    check("R2 ch2 compare D untouched", v, 'hFFFF);
  endtask

  task automatic t_counter_hold;
    int v1, v2;
    wr(ra(1, 'h00), 16'h0010);
    wr(ra(1, 'h14), 16'd1234);
    rd(ra(1, 'h14), v1);   check("R3 counter load", v1, 1234);
    wr(8'h00, 16'h2);
    rd(8'h00, v1);         check("R1 run register readback", v1, 2);
    repeat (20) @(negedge clk);
    wr(8'h00, 16'h0);
    rd(ra(1, 'h14), v1);
    check("R1 running counter advanced", int'(v1 > 1234), 1);
    repeat (20) @(negedge clk);
    rd(ra(1, 'h14), v2);   check("R1 stopped counter holds", v2, v1);
  endtask

  task automatic t_fixed;
    wr(8'h00, 16'h0);
    wr(ra(0, 'h08), 16'h0004);
    check("R9 stopped 100% level", int'(pwm_out[0]), 1);
    wr(ra(0, 'h08), 16'h0003);
    check("R9 stopped 0% level", int'(pwm_out[0]), 0);
  endtask

  task automatic t_normal_toggle;
    int hi, rs;
    wr(8'h00, 16'h0);
    wr(ra(2, 'h08), 16'h0000);
    wr(ra(2, 'h00), 16'((1 << 5) | (2 << 3)));
    wr(ra(2, 'h04), 16'h0000);
    wr(ra(2, 'h08), 16'h0003);
    wr(ra(2, 'h18), 16'd4);
    wr(ra(2, 'h14), 16'd0);
    wr(8'h00, 16'h4);
    repeat (50) @(negedge clk);
    measure(2, 200, hi, rs);
    check("R7 normal-mode toggle high cycles", hi, 100);
    check("R6 clear on A toggle count", rs, 20);
    wr(8'h00, 16'h0);
  endtask

  task automatic t_flags;
    int v;
    wr(8'h00, 16'h0);
    rd(ra(0, 'h10), v);    check("R10 flags after PWM run", v, 3);
    wr(ra(0, 'h10), 16'h0002);
    rd(ra(0, 'h10), v);    check("R10 clear A flag only", v, 2);
    wr(ra(0, 'h10), 16'h0000);
    rd(ra(0, 'h10), v);    check("R10 clear all flags", v, 0);
    // Count every clock, counter already at A, clear coincides with match
    wr(ra(0, 'h00), 16'((2 << 5) | (2 << 3)));
    wr(ra(0, 'h18), 16'd5);
    wr(ra(0, 'h1C), 16'd100);
    wr(ra(0, 'h14), 16'd5);
    wr(8'h00, 16'h1);
    wr(ra(0, 'h10), 16'h0000);
    wr(8'h00, 16'h0);
    rd(ra(0, 'h10), v);    check("R10 match beats same-cycle clear", v, 1);
    rd(ra(0, 'h14), v);    check("R3 counter advanced from A", int'(v > 5 && v < 9), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_counter_hold();
    t_fixed();
    // R4 rising: count every 2 clocks, period 20; R8 high 12 of 20
    run_pwm(0, 0, 200, 120, 10, "R4 R8 rising edge PWM");
    run_pwm(1, 0, 200, 120, 10, "R4 falling edge PWM");
    run_pwm(2, 0, 200, 120, 20, "R4 both edges PWM");
    // R5 p=1 both edges: one count per 4 clocks, period 40
    run_pwm(2, 1, 400, 240, 10, "R5 prescale 4 PWM");
    t_flags();
    t_normal_toggle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule